// File: doc/BRIEF.md
# Inactivity Power-Down Timeout Controller

This block is an inactivity timer for a battery-powered system. Its `pwr_down` output controls an external supply switch. A low level keeps the switch on. A high level asks for the supply to be removed. A counter runs from zero on every clock while the system is idle. Any closed key line, or the application pulling its active-low activity line low, sends the counter back to zero and holds `pwr_down` low.

When the count reaches the programmed modulus, a terminal flag sets and drives `pwr_down` high. The inverse of that flag is the counter's enable, so the count stops at the modulus and the flag stays set. Only a new key closure or activity indication clears it. The default modulus is 44,000,000, which gives about 10 seconds at a 4.4 MHz clock; any other timeout is set through the parameter. Key and activity inputs are asynchronous and pass through synchronizer flops before they act on the counter.

Top module: `inact_pwrdn_top`

## Requirements
- R1: While `rst_n` is low, `count_dbg` is 0 and `pwr_down` is low.
- R2: With no activity seen by the counter, `count_dbg` rises by exactly one on every rising clock edge until it reaches MODULUS.
- R3: `pwr_down` goes high on the same edge that `count_dbg` reaches MODULUS, which is MODULUS edges after the last edge that cleared the counter.
- R4: Once `pwr_down` is high and no activity arrives, `count_dbg` stays at MODULUS and `pwr_down` stays high.
- R5: A key line is closed when it is at logic 1. If any bit of `key_in` is 1 before a rising edge, `count_dbg` is 0 and `pwr_down` is low after the third rising edge counted from that edge (SYNC_STAGES = 2).
- R6: `act_n` at logic 0 clears the counter and `pwr_down` with the same three-edge latency as a key closure.
- R7: While a key or activity input stays active, `count_dbg` stays 0 and `pwr_down` stays low. Counting resumes at 1 on the first edge at which the synchronized inputs show no activity.
- R8: `count_dbg` never exceeds MODULUS.
- R9: `pwr_down` is high exactly when `count_dbg` equals MODULUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| key_in | input | NUM_KEYS | Key or matrix row lines, 1 = closed, asynchronous |
| act_n | input | 1 | Active-low activity indication from application logic, asynchronous |
| pwr_down | output | 1 | Supply shutdown request, low keeps power on |
| count_dbg | output | CW | Current inactivity count, CW = clog2(MODULUS+1) |

## Verification
The bench builds the block with MODULUS = 20, NUM_KEYS = 3 and SYNC_STAGES = 2. The short modulus makes full timeouts, the frozen terminal state and its release reachable many times within a few thousand cycles. Idle gaps are drawn randomly on both sides of the modulus, so activity lands just before, exactly at and after the terminal count. The three-edge synchronizer latency shows up directly in each clear.

// File: rtl/inact_pkg.sv
package inact_pkg;

  // Bits needed to hold the values 0..m inclusive.
  function automatic int unsigned count_width(input int unsigned m);
    int unsigned w;
    w = 1;
    while ((64'(1) << w) <= 64'(m)) w = w + 1;
    return w;
  endfunction

  // Next count while enabled: saturates at the modulus.
  function automatic int unsigned next_count(input int unsigned c,
                                             input int unsigned m);
    return (c >= m) ? m : c + 1;
  endfunction

  // True when the following enabled step reaches the modulus.
  function automatic logic at_last_step(input int unsigned c,
                                        input int unsigned m);
    return (c + 1 == m);
  endfunction

endpackage

// File: rtl/inact_sync.sv
module inact_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/inact_activity.sv
module inact_activity #(
  parameter int unsigned NUM_KEYS = 4
) (
  input  logic [NUM_KEYS-1:0] keys_s,
  input  logic                act_n_s,
  output logic                clear_evt
);

  logic any_key;

  always_comb begin
    any_key = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) any_key = any_key | keys_s[i];
  end

  assign clear_evt = any_key | ~act_n_s;

endmodule

// File: rtl/inact_timer.sv
module inact_timer #(
  parameter int unsigned MODULUS = 44_000_000,
  parameter int unsigned CW      = inact_pkg::count_width(MODULUS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_evt,
  output logic [CW-1:0] cnt_q,
  output logic          term_q,
  output logic          term_evt
);

  logic          cnt_en;
  logic          last_step;
  logic [CW-1:0] cnt_d;

  assign cnt_en    = ~term_q;
  assign last_step = inact_pkg::at_last_step(32'(cnt_q), MODULUS);
  assign cnt_d     = CW'(inact_pkg::next_count(32'(cnt_q), MODULUS));
  assign term_evt  = ~clear_evt & cnt_en & last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
    end else if (clear_evt) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      term_q <= last_step;
    end
  end

endmodule

// File: rtl/inact_pwrdn_top.sv
module inact_pwrdn_top #(
  parameter int unsigned MODULUS     = 44_000_000,
  parameter int unsigned NUM_KEYS    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = inact_pkg::count_width(MODULUS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] key_in,
  input  logic                act_n,
  output logic                pwr_down,
  output logic [CW-1:0]       count_dbg
);

  logic [NUM_KEYS-1:0] keys_s;
  logic                act_n_s;
  logic                clear_evt;
  logic                term_evt;
  logic                term_q;
  logic [CW-1:0]       cnt_q;

  inact_sync #(.W(NUM_KEYS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_key_sync (
    .clk(clk), .rst_n(rst_n), .d_async(key_in), .q_sync(keys_s)
  );

  inact_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_act_sync (
    .clk(clk), .rst_n(rst_n), .d_async(act_n), .q_sync(act_n_s)
  );

  inact_activity #(.NUM_KEYS(NUM_KEYS)) u_activity (
    .keys_s(keys_s), .act_n_s(act_n_s), .clear_evt(clear_evt)
  );

  inact_timer #(.MODULUS(MODULUS), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt),
    .cnt_q(cnt_q), .term_q(term_q), .term_evt(term_evt)
  );

  assign pwr_down  = term_q;
  assign count_dbg = cnt_q;

endmodule

// File: rtl/inact_pwrdn_chk.sv
module inact_pwrdn_chk #(
  parameter int unsigned MODULUS = 20,
  parameter int unsigned CW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_evt,
  input logic          term_evt,
  input logic          pwr_down,
  input logic [CW-1:0] count_dbg
);

  localparam logic [CW-1:0] MOD_C = CW'(MODULUS);

  // R2: idle and below the terminal count, the count advances by one
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_evt && count_dbg < MOD_C) |=> count_dbg == $past(count_dbg) + 1'b1);

  // R3: the terminal event raises the request on the next edge
  a_r3_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> (pwr_down && count_dbg == MOD_C));

  // R4: terminal state is frozen while idle
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !clear_evt) |=> (pwr_down && $stable(count_dbg)));

  // R7: any activity forces zero count and power held on
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (count_dbg == '0 && !pwr_down));

  // R8: count bound
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_dbg <= MOD_C);

  // R9: request tracks terminal count
  a_r9_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down == (count_dbg == MOD_C));

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_r1_reset: assert (!pwr_down && count_dbg == '0);
    end
  end

endmodule

bind inact_pwrdn_top inact_pwrdn_chk #(.MODULUS(MODULUS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .term_evt(term_evt),
  .pwr_down(pwr_down), .count_dbg(count_dbg)
);

// File: tb/inact_pwrdn_top_tb.sv
module inact_pwrdn_top_tb;
  localparam int unsigned MOD = 20;
  localparam int unsigned NK  = 3;
  localparam int unsigned CW  = inact_pkg::count_width(MOD);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NK-1:0] key_in = '0;
  logic          act_n = 1'b1;
  logic          pwr_down;
  logic [CW-1:0] count_dbg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [NK-1:0] m_k1 = '0, m_k2 = '0;
  logic          m_a1 = 1'b1, m_a2 = 1'b1;
  int            m_cnt = 0;

  inact_pwrdn_top #(.MODULUS(MOD), .NUM_KEYS(NK), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .act_n(act_n),
    .pwr_down(pwr_down), .count_dbg(count_dbg)
  );

  always #10 clk = ~clk;

  function automatic int exp_next(input int c, input bit activity);
    if (activity) return 0;
    if (c >= int'(MOD)) return int'(MOD);
    return c + 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model the edge, then compare at the falling edge
  task automatic step(input string tag);
    bit clr;
    @(posedge clk);
    clr   = (|m_k2) || !m_a2;
    m_cnt = exp_next(m_cnt, clr);
    m_k2  = m_k1; m_a2 = m_a1;
    m_k1  = key_in; m_a1 = act_n;
    @(negedge clk);
    check((m_cnt == int'(MOD)) ? "R3/R4 count" : {tag, " count"},
          int'(count_dbg), m_cnt);
    check("R9 pwr_down", int'(pwr_down), (m_cnt == int'(MOD)) ? 1 : 0);
    check("R8 bound", (int'(count_dbg) <= int'(MOD)) ? 1 : 0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 count", int'(count_dbg), 0);
    check("R1 pwr_down", int'(pwr_down), 0);
    rst_n = 1'b1;

    // R2/R3: full timeout from reset
    for (int i = 0; i < int'(MOD); i++) step("R2");
    check("R3 pwr_down at modulus", int'(pwr_down), 1);
    // R4: frozen terminal state
    for (int i = 0; i < 8; i++) step("R4");
    check("R4 still high", int'(pwr_down), 1);

    // R5: one-cycle key pulse, cleared after the third edge
    key_in = 3'b100;
    step("R5");
    key_in = '0;
    check("R5 edge1 still high", int'(pwr_down), 1);
    step("R5");
    check("R5 edge2 still high", int'(pwr_down), 1);
    step("R5");
    check("R5 edge3 cleared", int'(count_dbg), 0);
    check("R5 edge3 pwr low", int'(pwr_down), 0);
    for (int i = 0; i < 5; i++) step("R2");
    check("R2 resume", int'(count_dbg), 5);

    // R6/R7: held activity strobe
    act_n = 1'b0;
    for (int i = 0; i < 10; i++) step("R6/R7");
    check("R7 held zero", int'(count_dbg), 0);
    act_n = 1'b1;
    step("R7"); step("R7");
    check("R7 still zero", int'(count_dbg), 0);
    step("R7");
    check("R7 resume at 1", int'(count_dbg), 1);

    // random bursts around the modulus
    for (int b = 0; b < 160; b++) begin
      int idle;
      int busy;
      idle = $urandom_range(0, 2 * MOD);
      for (int i = 0; i < idle; i++) step("R2");
      busy = $urandom_range(1, 4);
      for (int i = 0; i < busy; i++) begin
        if ($urandom_range(0, 1) == 1) begin
          key_in = NK'($urandom_range(1, (1 << NK) - 1));
          act_n  = 1'b1;
          step("R5");
        end else begin
          key_in = '0;
          act_n  = 1'b0;
          step("R6");
        end
      end
      key_in = '0;
      act_n  = 1'b1;
    end
    for (int i = 0; i < int'(MOD) + 4; i++) step("R2");
    check("R4 final high", int'(pwr_down), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule